// File: doc/BRIEF.md
# Single-Precision Rounding Incrementer

This stage shortens a wide binary significand to single-precision length. The significand arrives with its hidden bit as the most significant bit. Alongside it come a sign, an unbiased exponent, three extra low-order bits from an earlier alignment step, and a 2-bit rounding mode.

The stage decides whether to add one unit in the last kept place. It returns the rounded significand with its discarded tail cleared, the exponent, and an inexact flag. When the increment carries out of the kept field, the significand is renormalised and the exponent goes up by one. Results are registered and appear one clock after the inputs.

The stage does not detect exponent overflow and does not classify special operands. Both belong to the converter around it.

Top module: `sp_round_stage`

## Requirements

Bit numbering used below: significand bit i, where bit 0 is the most significant, is port bit FRAC_W-1-i of `frac_in` and `frac_out`.

- R1: While `rst_n` is low, `frac_out`, `exp_out` and `inexact_out` are all zero.
- R2: Each result appears on the outputs one clock edge after its inputs are sampled.
- R3: The kept field is significand bits 0 to KEEP_W-1. Output significand bits KEEP_W to FRAC_W-1 are always zero.
- R4: The sticky term is the OR of significand bits KEEP_W+2 to FRAC_W-1 and the external inputs `g_in`, `r_in` and `x_in`. The guard bit is significand bit KEEP_W, and the round bit is significand bit KEEP_W+1.
- R5: Mode 00 (nearest) increments in two cases. The first is when the lsb (significand bit KEEP_W-1) and the guard bit are both 1. The second is when the lsb is 0, the guard bit is 1, and the round or sticky bit is 1.
- R6: Mode 01 (toward zero) never increments.
- R7: Mode 10 (toward +infinity) increments only when the sign is 0 and any of guard, round or sticky is 1.
- R8: Mode 11 (toward -infinity) increments only when the sign is 1 and any of guard, round or sticky is 1.
- R9: If the increment carries out of the kept field, the output significand is a 1 followed by the upper KEEP_W-1 bits of the incremented field (all zero), and the exponent is incremented.
- R10: Without a carry-out, the exponent passes through unchanged. Exponent arithmetic wraps modulo 2^EXP_W.
- R11: `inexact_out` is the OR of the guard, round and sticky bits.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_in | input | 1 | Operand sign, 1 = negative |
| exp_in | input | EXP_W | Unbiased exponent, two's complement |
| frac_in | input | FRAC_W | Significand, hidden bit at the MSB |
| g_in | input | 1 | External low-order bit, folded into sticky |
| r_in | input | 1 | External low-order bit, folded into sticky |
| x_in | input | 1 | External low-order bit, folded into sticky |
| mode_in | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| frac_out | output | FRAC_W | Rounded significand, tail cleared |
| exp_out | output | EXP_W | Exponent after rounding |
| inexact_out | output | 1 | Discarded bits were nonzero |

## Verification

The bench builds the stage with FRAC_W=10, KEEP_W=4 and EXP_W=4. This leaves a 4-bit kept field, a guard bit, a round bit and a 4-bit sticky tail. With these values every significand, external bit pattern, sign and mode can be swept, 65,536 combinations in all. Every tie, every all-ones carry-out, and every exponent wrap is therefore reached. Expected results are computed with integer arithmetic on the kept field.

// File: rtl/sp_round_stage.sv
module sp_round_stage #(
  parameter int FRAC_W = 53,
  parameter int KEEP_W = 24,
  parameter int EXP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sign_in,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic              g_in,
  input  logic              r_in,
  input  logic              x_in,
  input  logic [1:0]        mode_in,
  output logic [FRAC_W-1:0] frac_out,
  output logic [EXP_W-1:0]  exp_out,
  output logic              inexact_out
);
  localparam int LSB_P = FRAC_W - KEEP_W;
  localparam int GRD_P = LSB_P - 1;
  localparam int RND_P = LSB_P - 2;
  localparam int TAIL_W = LSB_P - 2;

  logic [KEEP_W-1:0] kept;
  logic              guard, rnd, sticky, lsb, loose, inc;
  logic [KEEP_W:0]   sum;
  logic [KEEP_W-1:0] next_kept;
  logic [EXP_W-1:0]  next_exp;

  assign kept   = frac_in[FRAC_W-1:LSB_P];
  assign lsb    = frac_in[LSB_P];
  assign guard  = frac_in[GRD_P];
  assign rnd    = frac_in[RND_P];
  assign sticky = (|frac_in[TAIL_W-1:0]) | g_in | r_in | x_in;
  assign loose  = guard | rnd | sticky;

  always_comb begin
    case (mode_in)
      2'b00:   inc = guard & (lsb | rnd | sticky);
      2'b10:   inc = ~sign_in & loose;
      2'b11:   inc = sign_in & loose;
      default: inc = 1'b0;
    endcase
  end

  assign sum       = {1'b0, kept} + {{KEEP_W{1'b0}}, inc};
  assign next_kept = sum[KEEP_W] ? sum[KEEP_W:1] : sum[KEEP_W-1:0];
  assign next_exp  = exp_in + {{(EXP_W-1){1'b0}}, sum[KEEP_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_out    <= '0;
      exp_out     <= '0;
      inexact_out <= 1'b0;
    end else begin
      frac_out    <= {next_kept, {LSB_P{1'b0}}};
      exp_out     <= next_exp;
      inexact_out <= loose;
    end
  end

  assert_rtz_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_in) == 2'b01) |->
      (frac_out[FRAC_W-1:LSB_P] == $past(frac_in[FRAC_W-1:LSB_P]) && exp_out == $past(exp_in)));

  assert_pinf_neg_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_in) == 2'b10 && $past(sign_in)) |->
      (frac_out[FRAC_W-1:LSB_P] == $past(frac_in[FRAC_W-1:LSB_P])));

  assert_minf_pos_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_in) == 2'b11 && !$past(sign_in)) |->
      (frac_out[FRAC_W-1:LSB_P] == $past(frac_in[FRAC_W-1:LSB_P])));

  assert_exact_passes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !inexact_out) |->
      (frac_out[FRAC_W-1:LSB_P] == $past(frac_in[FRAC_W-1:LSB_P]) && exp_out == $past(exp_in)));

  assert_carry_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && exp_out != $past(exp_in)) |->
      (frac_out[FRAC_W-1] && $countones(frac_out) == 1));
endmodule

// File: tb/tb_sp_round_stage.sv
`timescale 1ns/1ps
module tb_sp_round_stage;
  localparam int FW = 10, KW = 4, EW = 4, LP = FW - KW;

  logic clk = 0, rst_n = 0;
  logic sign_in = 0, g_in = 0, r_in = 0, x_in = 0;
  logic [EW-1:0] exp_in = '0;
  logic [FW-1:0] frac_in = '0;
  logic [1:0] mode_in = 2'b00;
  logic [FW-1:0] frac_out;
  logic [EW-1:0] exp_out;
  logic inexact_out;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  sp_round_stage #(.FRAC_W(FW), .KEEP_W(KW), .EXP_W(EW)) dut (
    .clk, .rst_n, .sign_in, .exp_in, .frac_in, .g_in, .r_in, .x_in, .mode_in,
    .frac_out, .exp_out, .inexact_out);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic [EW-1:0] e, input logic [FW-1:0] f,
                       input logic [2:0] grx, input logic [1:0] m);
    sign_in = s; exp_in = e; frac_in = f; {g_in, r_in, x_in} = grx; mode_in = m;
  endtask

  // R2: inputs applied at a falling edge are checked at the next falling edge
  task automatic verify(input logic s, input logic [EW-1:0] e, input logic [FW-1:0] f,
                        input logic [2:0] grx, input logic [1:0] m);
    int kept, lsb, g, r, st, lo, inc, sum, ek, ee;
    string mt;
    kept = int'(f) >> LP;
    lsb = kept & 1;
    g = int'(f[LP-1]);
    r = int'(f[LP-2]);
    st = ((f[LP-3:0] != 0) || grx != 0) ? 1 : 0;   // R4
    lo = g | r | st;
    case (m)
      2'b00: begin inc = g & (lsb | r | st); mt = "R5"; end
      2'b01: begin inc = 0; mt = "R6"; end
      2'b10: begin inc = (s == 0) ? lo : 0; mt = "R7"; end
      default: begin inc = (s == 1) ? lo : 0; mt = "R8"; end
    endcase
    sum = kept + inc;
    if (sum >= (1 << KW)) begin ek = sum >> 1; ee = (int'(e) + 1) % (1 << EW); end // R9
    else begin ek = sum; ee = int'(e); end                                         // R10
    chk(mt, int'(frac_out) >> LP, ek);
    chk("R3", int'(frac_out[LP-1:0]), 0);
    chk("R10", int'(exp_out), ee);
    chk("R11", int'(inexact_out), lo);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    apply(1, 4'h7, 10'h3FF, 3'b111, 2'b10);
    @(posedge clk); @(negedge clk);
    chk("R1 frac", int'(frac_out), 0);
    chk("R1 exp", int'(exp_out), 0);
    chk("R1 inexact", int'(inexact_out), 0);
    rst_n = 1;

    // R4: external bits alone feed sticky (mode +inf, positive, kept 1010)
    for (int k = 0; k < 3; k++) begin
      apply(0, 4'h2, 10'b1010_000000, 3'b100 >> k, 2'b10);
      @(negedge clk);
      chk("R4 frac", int'(frac_out) >> LP, 4'b1011);
      chk("R4 inexact", int'(inexact_out), 1);
    end

    // R9 with R10 wrap: all-ones kept field, guard set, nearest, exp at max
    apply(0, 4'hF, 10'b1111_100000, 3'b000, 2'b00);
    @(negedge clk);
    chk("R9 frac", int'(frac_out), 10'b1000_000000);
    chk("R10 wrap", int'(exp_out), 0);

    for (int v = 0; v < 65536; v++) begin
      logic s; logic [EW-1:0] e; logic [FW-1:0] f; logic [2:0] grx; logic [1:0] m;
      f = v[9:0]; grx = v[12:10]; s = v[13]; m = v[15:14]; e = 4'(v * 5 + (v >> 10));
      apply(s, e, f, grx, m);
      @(negedge clk);
      verify(s, e, f, grx, m);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule